// File: doc/BRIEF.md
# 8N1 Serial Port with Byte Register File

This block is a serial port peripheral that sits on a plain address/data/strobe bus. Software reaches it through eight byte-wide registers placed on word-aligned addresses. The serial format is fixed: one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity.

Received characters go into a four-entry FIFO. Characters to send go into a single holding register, which is also the shift register. A 16-bit divisor sets a tick rate of four ticks per bit. The status byte holds several kinds of field:

- two interrupt enables that software can read and write;
- FIFO and transmitter flags that are read-only;
- two sticky error flags, which software clears by writing 0.

The receive and transmit interrupt conditions are combined onto one interrupt line.

The bus read path is combinational. The read strobe has an effect only on the data register, where it removes the oldest FIFO entry at the clock edge.

Top module: `serial_port8n1`

## Requirements
- R1: After reset the status byte reads 0xA0, the divisor bytes read 0, `irq` is 0 and `txd` is 1.
- R2: The register addresses are:
  - identification constants at 0, 4, 8 and 12;
  - data at 16;
  - status at 20;
  - divisor low byte at 24 and high byte at 28.

  Any other address reads 0. The status bits are:
  - bit0: frame error
  - bit1: overflow
  - bit2: receive interrupt enable
  - bit3: FIFO full
  - bit4: FIFO holds three entries
  - bit5: FIFO empty
  - bit6: transmit interrupt enable
  - bit7: transmitter idle
- R3: A received character appears in the FIFO, and reads of the data register return characters in arrival order. Each read removes one entry. A read while the FIFO is empty returns 0.
- R4: Status bit4 is 1 exactly when three entries are held. Bit3 is 1 exactly when four entries are held. Bit5 is 1 exactly when no entries are held.
- R5: A character that completes while the FIFO is full is dropped and sets bit1. The entries already stored are unchanged.
- R6: A character whose stop bit samples low still enters the FIFO and sets bit0. The receiver then waits for the line to go high before it looks for the next start bit.
- R7: Each status write affects the fields as follows:
  - bits 0 and 1 clear when written 0 and are kept when written 1;
  - bits 2 and 6 take the written value;
  - bits 3, 4, 5 and 7 ignore the write.
- R8: A write to the data register while bit7 is 1 clears bit7 and sends the character on `txd`: start bit low, data LSB first, stop bit high. Bit7 returns to 1 after the stop bit. A data write while bit7 is 0 is ignored.
- R9: The bit time is 4×(divisor+1) clock cycles. The receiver accepts a start bit at its second low tick and samples each later bit every fourth tick.
- R10: `irq` is 1 when either of these holds:
  - bit2 is set and the FIFO is not empty or an error bit is set;
  - bit6 and bit7 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; pops the FIFO when the address is the data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Combined receive/transmit interrupt |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |

## Verification
A wrong FIFO count shows up at once in status bits 3 to 5, at the next status read. A wrong read pointer shows up on the first data read as a character returned out of order. A receiver whose sample phase is off by a tick or more yields wrong data or a false frame error when the character completes, about ten bit times after the start edge. A transmitter with a bad bit counter shows on `txd` within one bit time, and shows on status bit7 when the transmitter fails to return to idle after the frame.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int OFS_ID0   = 0;
  localparam int OFS_ID1   = 4;
  localparam int OFS_ID2   = 8;
  localparam int OFS_ID3   = 12;
  localparam int OFS_DATA  = 16;
  localparam int OFS_STAT  = 20;
  localparam int OFS_DIVLO = 24;
  localparam int OFS_DIVHI = 28;

  localparam int SB_FERR    = 0;
  localparam int SB_OVF     = 1;
  localparam int SB_RXIE    = 2;
  localparam int SB_RXFULL  = 3;
  localparam int SB_RXLAST  = 4;
  localparam int SB_RXEMPTY = 5;
  localparam int SB_TXIE    = 6;
  localparam int SB_TXEMPTY = 7;

  localparam int OVERSAMPLE = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_WAITHI} rx_state_e;

  // sticky flag: a new event wins, a written 0 clears, a written 1 keeps
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic wr, input logic wbit);
    if (set_ev) return 1'b1;
    if (wr && !wbit) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/sp_baud_tick.sv
module sp_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sp_tx_shift.sv
module sp_tx_shift #(
  parameter int DATA_W = 8,
  parameter int OVS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              txd
);
  localparam int FR = DATA_W + 2;
  localparam int BW = $clog2(FR + 1);
  localparam int PW = $clog2(OVS);

  logic [FR-1:0] shreg;
  logic [BW-1:0] bitn;
  logic [PW-1:0] ph;
  logic          bit_end;

  assign bit_end = tick && (ph == PW'(OVS - 1));
  assign txd     = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      bitn  <= '0;
      ph    <= '0;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        shreg <= {1'b1, din, 1'b0};
        bitn  <= '0;
        ph    <= '0;
        busy  <= 1'b1;
      end
    end else if (tick) begin
      if (bit_end) begin
        ph    <= '0;
        shreg <= {1'b1, shreg[FR-1:1]};
        if (bitn == BW'(FR - 1)) busy <= 1'b0;
        else                     bitn <= bitn + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_busy_from_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load));
endmodule

// File: rtl/sp_rx_sample.sv
module sp_rx_sample #(
  parameter int DATA_W = 8,
  parameter int OVS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ferr
);
  import sp_pkg::*;
  localparam int PW    = $clog2(OVS);
  localparam int BW    = $clog2(DATA_W + 1);
  localparam int START = OVS / 2;

  logic [1:0]  sync;
  logic        rx_s;
  rx_state_e   st;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;

  assign rx_s = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      ph   <= '0;
      bitn <= '0;
      data <= '0;
      done <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (tick) begin
          if (rx_s) ph <= '0;
          else if (ph == PW'(START - 1)) begin
            st   <= RX_BITS;
            ph   <= '0;
            bitn <= '0;
          end else ph <= ph + 1'b1;
        end
        RX_BITS: if (tick) begin
          if (ph == PW'(OVS - 1)) begin
            ph <= '0;
            if (bitn == BW'(DATA_W)) begin
              done <= 1'b1;
              ferr <= !rx_s;
              st   <= rx_s ? RX_IDLE : RX_WAITHI;
            end else begin
              data <= {rx_s, data[DATA_W-1:1]};
              bitn <= bitn + 1'b1;
            end
          end else ph <= ph + 1'b1;
        end
        default: if (rx_s) st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sp_rx_fifo.sv
module sp_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= ptr_inc(wp);
      if (do_pop)  rp <= ptr_inc(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));
endmodule

// File: rtl/serial_port8n1.sv
module serial_port8n1 #(
  parameter int         ADDR_W   = 5,
  parameter int         RX_DEPTH = 4,
  parameter logic [7:0] ID0      = 8'h5E,
  parameter logic [7:0] ID1      = 8'h01,
  parameter logic [7:0] ID2      = 8'h00,
  parameter logic [7:0] ID3      = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              txd,
  input  logic              rxd
);
  import sp_pkg::*;
  localparam int DIV_W = 16;
  localparam int CW    = $clog2(RX_DEPTH + 1);

  logic [DIV_W-1:0] div;
  logic             tick, tx_busy, tx_empty;
  logic             rx_done, rx_ferr;
  logic [7:0]       rx_data, fifo_dout;
  logic [CW-1:0]    fifo_cnt;
  logic             fifo_full, fifo_empty, fifo_last;
  logic             rx_ie, tx_ie, err_f, err_o;
  logic             sel_data, sel_stat, sel_lo, sel_hi, wr_stat;
  logic             push, pop;
  logic [7:0]       status;

  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_lo   = (bus_addr == ADDR_W'(OFS_DIVLO));
  assign sel_hi   = (bus_addr == ADDR_W'(OFS_DIVHI));
  assign wr_stat  = bus_wr && sel_stat;

  assign fifo_full  = (fifo_cnt == CW'(RX_DEPTH));
  assign fifo_last  = (fifo_cnt == CW'(RX_DEPTH - 1));
  assign fifo_empty = (fifo_cnt == '0);
  assign tx_empty   = !tx_busy;
  assign push       = rx_done && !fifo_full;
  assign pop        = bus_rd && sel_data && !fifo_empty;

  sp_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

  sp_tx_shift #(.DATA_W(8), .OVS(OVERSAMPLE)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(bus_wr && sel_data),
    .din(bus_wdata), .busy(tx_busy), .txd(txd));

  sp_rx_sample #(.DATA_W(8), .OVS(OVERSAMPLE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .done(rx_done), .data(rx_data), .ferr(rx_ferr));

  sp_rx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(rx_data), .pop(pop),
    .dout(fifo_dout), .count(fifo_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
      err_f <= 1'b0;
      err_o <= 1'b0;
    end else begin
      if (bus_wr && sel_lo) div[7:0]  <= bus_wdata;
      if (bus_wr && sel_hi) div[15:8] <= bus_wdata;
      if (wr_stat) begin
        rx_ie <= bus_wdata[SB_RXIE];
        tx_ie <= bus_wdata[SB_TXIE];
      end
      err_f <= sticky_next(err_f, rx_done && rx_ferr, wr_stat, bus_wdata[SB_FERR]);
      err_o <= sticky_next(err_o, rx_done && fifo_full, wr_stat, bus_wdata[SB_OVF]);
    end
  end

  always_comb begin
    status             = '0;
    status[SB_FERR]    = err_f;
    status[SB_OVF]     = err_o;
    status[SB_RXIE]    = rx_ie;
    status[SB_RXFULL]  = fifo_full;
    status[SB_RXLAST]  = fifo_last;
    status[SB_RXEMPTY] = fifo_empty;
    status[SB_TXIE]    = tx_ie;
    status[SB_TXEMPTY] = tx_empty;
  end

  always_comb begin
    case (int'(bus_addr))
      OFS_ID0:   bus_rdata = ID0;
      OFS_ID1:   bus_rdata = ID1;
      OFS_ID2:   bus_rdata = ID2;
      OFS_ID3:   bus_rdata = ID3;
      OFS_DATA:  bus_rdata = fifo_empty ? 8'h00 : fifo_dout;
      OFS_STAT:  bus_rdata = status;
      OFS_DIVLO: bus_rdata = div[7:0];
      OFS_DIVHI: bus_rdata = div[15:8];
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign irq = (rx_ie && (!fifo_empty || err_f || err_o)) || (tx_ie && tx_empty);

  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(rx_done && fifo_full));
  assert_ferr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_f) |-> $past(rx_done && rx_ferr));
  assert_tx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ie && !tx_busy) |-> irq);
  assert_pop_only_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt < $past(fifo_cnt)) |-> $past(bus_rd && sel_data));
endmodule

// File: tb/serial_port8n1_tb.sv
module serial_port8n1_tb;
  localparam int BIT = 8;   // divisor 1 -> 4*(1+1) cycles per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, txd;
  logic       rxd = 1'b1;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model
  byte unsigned q[$];
  bit m_ferr = 0, m_ovf = 0, m_rxie = 0, m_txie = 0, m_txe = 1;

  always #4 clk = ~clk;

  serial_port8n1 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd));

  function automatic logic [7:0] exp_sts();
    return {m_txe, m_txie, q.size() == 0, q.size() == 3, q.size() == 4,
            m_rxie, m_ovf, m_ferr};
  endfunction

  function automatic logic exp_irq();
    return (m_rxie && (q.size() != 0 || m_ferr || m_ovf)) || (m_txie && m_txe);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); bus_addr = a[4:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); bus_addr = a[4:0]; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    wr(20, d);
    m_rxie = d[2];
    m_txie = d[6];
    if (!d[0]) m_ferr = 0;
    if (!d[1]) m_ovf = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit good_stop);
    logic [9:0] fr;
    fr = {good_stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd = fr[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (6) @(negedge clk);
    if (q.size() >= 4) m_ovf = 1; else q.push_back(b);
    if (!good_stop) m_ferr = 1;
  endtask

  task automatic chk_sts(input string req);
    logic [7:0] v;
    rd(20, v);
    chk(req, v, exp_sts());
    chk({req, " irq"}, {7'd0, irq}, {7'd0, exp_irq()});
  endtask

  task automatic pop_chk(input string req);
    logic [7:0] v, e;
    e = (q.size() != 0) ? q.pop_front() : 8'h00;
    rd(16, v);
    chk(req, v, e);
  endtask

  task automatic tx_frame(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    wr(16, b);            // load at edge P, back at P+0.5
    wr(16, 8'hFF);        // busy: must be ignored (R8), back at P+2.5
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk($sformatf("R8 R9 tx bit %0d", i), {7'd0, txd}, {7'd0, fr[i]});
      repeat (BIT) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R3: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", {7'd0, txd}, 8'd1);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rd(20, v); chk("R1 status", v, 8'hA0);
    rd(24, v); chk("R1 div lo", v, 8'h00);
    rd(28, v); chk("R1 div hi", v, 8'h00);
    // R2 map
    rd(0, v);  chk("R2 id0", v, 8'h5E);
    rd(4, v);  chk("R2 id1", v, 8'h01);
    rd(12, v); chk("R2 id3", v, 8'h03);
    rd(2, v);  chk("R2 unmapped", v, 8'h00);
    // R9 divisor
    wr(24, 8'h01);
    rd(24, v); chk("R9 div lo", v, 8'h01);
    // R3 single receive
    send(8'h96, 1);
    chk_sts("R3 after rx");
    pop_chk("R3 data");
    chk_sts("R3 emptied");
    pop_chk("R3 empty read");
    // R4 / R5 fill and overflow
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1);
    chk_sts("R4 three held");
    send(8'h44, 1);
    chk_sts("R4 full");
    send(8'h55, 1);
    chk_sts("R5 overflow");
    for (int i = 0; i < 4; i++) pop_chk("R5 order kept");
    chk_sts("R5 after drain");
    // R7 writes: clear ovf (bit1=0), keep bit0, enables on
    wr_stat(8'hFD);
    chk_sts("R7 R10 enables on");
    wr_stat(8'hBB);       // flag bits written 1, enables off, errors kept
    chk_sts("R7 flags ignore writes");
    // R6 frame error, then clean frame after it
    send(8'h7E, 0);
    chk_sts("R6 frame error");
    wr_stat(8'h05);       // rx enable, keep ferr
    chk_sts("R10 rx irq");
    pop_chk("R6 char kept");
    chk_sts("R10 irq by error");
    wr_stat(8'h04);       // clear ferr
    chk_sts("R7 ferr cleared");
    send(8'hA5, 1);
    chk_sts("R6 recovery");
    pop_chk("R6 next char");
    wr_stat(8'h00);
    // R8 transmit
    tx_frame(8'h5A);
    chk_sts("R8 idle after frame");
    wr_stat(8'h40);
    chk("R10 tx irq", {7'd0, irq}, 8'd1);
    wr(16, 8'hC3); m_txe = 0;
    chk("R8 R10 irq drops", {7'd0, irq}, 8'd0);
    chk_sts("R8 busy");
    repeat (11 * BIT) @(negedge clk); m_txe = 1;
    chk_sts("R8 R10 done");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule